// File: doc/BRIEF.md
# Mixed-Width Dual-Port RAM with Parity Lanes

This block is a true dual-port synchronous memory that holds 16,384 data bits and 2,048 parity bits in one shared array. Each of its two ports is given its own word width when the block is elaborated (1, 2, 4, 9, 18 or 36 bits), so a wide producer and a narrow consumer can share storage with no width converter between them. The port word is split into a data bus (1, 2, 4, 8, 16 or 32 bits) and, at the byte-multiple widths, a parity bus of one bit per data byte.

Both ports present a 14-bit address whatever their width. A port keeps only the upper address bits it needs and drops the rest, so one address value names the same bit position from either side. A narrow port reaches one slice of a 36-bit storage row. The low address bits pick the slice, and slice zero sits in the lowest data lanes. Read data is registered, and each port has its own write mode. That mode decides what the port's read bus shows on a cycle when the same port writes: the new word, the word it replaces, or the last value unchanged.

Storage is organised as 512 rows of 36 bits: 32 data bits and 4 parity bits, with parity bit j guarding data byte j. Port enable and write enable share one clock. A synchronous active-high reset clears the read registers and leaves the array alone.

Top module: `mixram_dp`

## Requirements
- R1: A port of width 1, 2, 4, 9, 18 or 36 decodes address bits [13:0], [13:1], [13:2], [13:3], [13:4] or [13:5] respectively, and the remaining low address bits have no effect on which location is read or written.
- R2: Address bits [13:5] select one of 512 rows, and a port with data width DW reaches data lane k = addr[4:0] / DW, which covers row data bits [k*DW +: DW]. Data written through one port width is read back at the same bit positions through the other width.
- R3: Widths 9, 18 and 36 carry 1, 2 and 4 parity bits above 8, 16 and 32 data bits, and parity lane k covers row parity bits [k*PW +: PW], so parity bit j belongs to data byte j. At widths 1, 2 and 4 the 1-bit parity input is ignored and the parity output reads 0.
- R4: Read data changes only at a clock edge where the port is enabled, and then shows the row contents at the address sampled on that edge.
- R5: With the enable low, a port neither writes (even with its write enable high) nor changes its read outputs.
- R6: In new-data mode, a write on an enabled port puts the written data and parity on that port's read outputs after the same edge.
- R7: In old-data mode, a write on an enabled port puts the contents that were stored before the write on that port's read outputs.
- R8: In hold mode, a write on an enabled port leaves that port's read outputs unchanged.
- R9: A read on one port in the same cycle as a write by the other port to the same location returns the stored value from before the write. The next read returns the new value.
- R10: Reset clears both read-data and read-parity registers to 0 and does not alter the stored array.
- R11: Writes from both ports in the same cycle to disjoint bits of the same row both take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both ports |
| rst | input | 1 | Synchronous active-high reset of the read registers |
| a_en | input | 1 | Port A enable |
| a_we | input | 1 | Port A write enable |
| a_addr | input | 14 | Port A address, upper bits used |
| a_din | input | data width of A | Port A write data |
| a_pin | input | max(1, parity width of A) | Port A write parity |
| a_dout | output | data width of A | Port A registered read data |
| a_pout | output | max(1, parity width of A) | Port A registered read parity |
| b_en | input | 1 | Port B enable |
| b_we | input | 1 | Port B write enable |
| b_addr | input | 14 | Port B address, upper bits used |
| b_din | input | data width of B | Port B write data |
| b_pin | input | max(1, parity width of B) | Port B write parity |
| b_dout | output | data width of B | Port B registered read data |
| b_pout | output | max(1, parity width of B) | Port B registered read parity |

## Verification
Three instances cover the width pairs 36/9, 18/1 and 2/4, and between them each write mode appears on more than one width. A bit-level reference array models each instance. Writes through the wide port read back through the narrow lanes, and the reverse, which shows whether the lane order and the parity-to-byte pairing are right. Addresses with their ignored low bits set to all ones show whether those bits leak into the decode. Same-cycle traffic on both ports shows two things: a read on one port against a write on the other returns the old value, and writes to disjoint bits of one row merge. A write with the enable low and a reset partway through the run show that neither one touches the stored contents.

// File: rtl/mixram_pkg.sv
`timescale 1ns/1ps
package mixram_pkg;

    parameter int ADDR_W   = 14;
    parameter int ROW_DATA = 32;
    parameter int ROW_PAR  = ROW_DATA / 8;
    parameter int ROW_W    = ROW_DATA + ROW_PAR;
    parameter int ROWS     = (1 << ADDR_W) / ROW_DATA;
    parameter int ROW_AW   = $clog2(ROWS);
    parameter int LANE_AW  = $clog2(ROW_DATA);

    typedef enum logic [1:0] {
        WM_NEW_DATA = 2'd0,
        WM_OLD_DATA = 2'd1,
        WM_HOLD     = 2'd2
    } wmode_e;

    typedef struct packed {
        logic [ROW_AW-1:0] row;
        logic [ROW_W-1:0]  mask;
        logic [ROW_W-1:0]  val;
    } row_wr_t;

    function automatic bit width_ok(input int w);
        return (w == 1) || (w == 2) || (w == 4) || (w == 9) || (w == 18) || (w == 36);
    endfunction

    function automatic int data_w(input int w);
        case (w)
            1:       return 1;
            2:       return 2;
            4:       return 4;
            9:       return 8;
            18:      return 16;
            default: return 32;
        endcase
    endfunction

    function automatic int par_w(input int w);
        case (w)
            9:       return 1;
            18:      return 2;
            36:      return 4;
            default: return 0;
        endcase
    endfunction

    function automatic int bus_w(input int n);
        return (n < 1) ? 1 : n;
    endfunction

    function automatic int addr_lsb(input int w);
        return $clog2(data_w(w));
    endfunction

    function automatic int lane_of(input logic [ADDR_W-1:0] addr, input int w);
        return int'(addr[LANE_AW-1:0]) >> addr_lsb(w);
    endfunction

    function automatic logic [ROW_DATA-1:0] data_ones(input int n);
        logic [ROW_DATA-1:0] r;
        r = '0;
        for (int i = 0; i < ROW_DATA; i++) begin
            if (i < n) r[i] = 1'b1;
        end
        return r;
    endfunction

    function automatic logic [ROW_PAR-1:0] par_ones(input int n);
        logic [ROW_PAR-1:0] r;
        r = '0;
        for (int i = 0; i < ROW_PAR; i++) begin
            if (i < n) r[i] = 1'b1;
        end
        return r;
    endfunction

    function automatic logic [ROW_W-1:0] merge_row(input logic [ROW_W-1:0] old,
                                                   input row_wr_t        wr);
        return (old & ~wr.mask) | (wr.val & wr.mask);
    endfunction

endpackage

// File: rtl/mixram_lane_map.sv
`timescale 1ns/1ps
module mixram_lane_map import mixram_pkg::*; #(
    parameter int WIDTH = 36
) (
    input  logic [ADDR_W-1:0]                addr,
    input  logic [data_w(WIDTH)-1:0]         din,
    input  logic [bus_w(par_w(WIDTH))-1:0]   pin,
    output row_wr_t                          wr
);
    localparam int DW = data_w(WIDTH);
    localparam int PW = par_w(WIDTH);

    int lane;

    always_comb begin
        lane    = lane_of(addr, WIDTH);
        wr.row  = addr[ADDR_W-1 -: ROW_AW];
        wr.mask = '0;
        wr.val  = '0;
        wr.mask[ROW_DATA-1:0] = data_ones(DW) << (lane * DW);
        wr.val[ROW_DATA-1:0]  = ROW_DATA'(din) << (lane * DW);
        if (PW > 0) begin
            wr.mask[ROW_W-1:ROW_DATA] = par_ones(PW) << (lane * PW);
            wr.val[ROW_W-1:ROW_DATA]  = ROW_PAR'(pin) << (lane * PW);
        end
    end

endmodule

// File: rtl/mixram_lane_pick.sv
`timescale 1ns/1ps
module mixram_lane_pick import mixram_pkg::*; #(
    parameter int WIDTH = 36
) (
    input  logic [ROW_W-1:0]                 row_q,
    input  logic [ADDR_W-1:0]                addr,
    output logic [data_w(WIDTH)-1:0]         dout,
    output logic [bus_w(par_w(WIDTH))-1:0]   pout
);
    localparam int DW = data_w(WIDTH);
    localparam int PW = par_w(WIDTH);
    localparam int PB = bus_w(PW);

    int lane;

    always_comb begin
        lane = lane_of(addr, WIDTH);
        dout = DW'(row_q[ROW_DATA-1:0] >> (lane * DW));
        if (PW > 0) pout = PB'(row_q[ROW_W-1:ROW_DATA] >> (lane * PW));
        else        pout = '0;
    end

endmodule

// File: rtl/mixram_rdreg.sv
`timescale 1ns/1ps
module mixram_rdreg import mixram_pkg::*; #(
    parameter int     DW   = 32,
    parameter int     PB   = 4,
    parameter wmode_e MODE = WM_NEW_DATA
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          we,
    input  logic [DW-1:0] old_d,
    input  logic [PB-1:0] old_p,
    input  logic [DW-1:0] new_d,
    input  logic [PB-1:0] new_p,
    output logic [DW-1:0] dout,
    output logic [PB-1:0] pout
);
    typedef struct packed {
        logic [PB-1:0] p;
        logic [DW-1:0] d;
    } pword_t;

    pword_t q, nxt;
    logic   upd;
    logic   unused_rd;

    assign unused_rd = ^{new_d, new_p, we};

    generate
        case (MODE)
            WM_NEW_DATA: begin : g_new
                assign upd = en;
                assign nxt = we ? pword_t'{p: new_p, d: new_d} : pword_t'{p: old_p, d: old_d};
            end
            WM_OLD_DATA: begin : g_old
                assign upd = en;
                assign nxt = pword_t'{p: old_p, d: old_d};
            end
            default: begin : g_hold
                assign upd = en & ~we;
                assign nxt = pword_t'{p: old_p, d: old_d};
            end
        endcase
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)      q <= '0;
        else if (upd) q <= nxt;
    end

    assign dout = q.d;
    assign pout = q.p;

endmodule

// File: rtl/mixram_port.sv
`timescale 1ns/1ps
module mixram_port import mixram_pkg::*; #(
    parameter int     WIDTH = 36,
    parameter wmode_e MODE  = WM_NEW_DATA
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             en,
    input  logic                             we,
    input  logic [ADDR_W-1:0]                addr,
    input  logic [data_w(WIDTH)-1:0]         din,
    input  logic [bus_w(par_w(WIDTH))-1:0]   pin,
    input  logic [ROW_W-1:0]                 row_q,
    output row_wr_t                          wr,
    output logic                             wr_go,
    output logic [data_w(WIDTH)-1:0]         dout,
    output logic [bus_w(par_w(WIDTH))-1:0]   pout
);
    localparam int DW = data_w(WIDTH);
    localparam int PW = par_w(WIDTH);
    localparam int PB = bus_w(PW);

    logic [DW-1:0] old_d;
    logic [PB-1:0] old_p;
    logic [PB-1:0] new_p;

    assign wr_go = en & we;
    assign new_p = (PW > 0) ? pin : '0;

    mixram_lane_map #(.WIDTH(WIDTH)) map_i (
        .addr (addr),
        .din  (din),
        .pin  (pin),
        .wr   (wr)
    );

    mixram_lane_pick #(.WIDTH(WIDTH)) pick_i (
        .row_q (row_q),
        .addr  (addr),
        .dout  (old_d),
        .pout  (old_p)
    );

    mixram_rdreg #(.DW(DW), .PB(PB), .MODE(MODE)) rd_i (
        .clk   (clk),
        .rst   (rst),
        .en    (en),
        .we    (we),
        .old_d (old_d),
        .old_p (old_p),
        .new_d (din),
        .new_p (new_p),
        .dout  (dout),
        .pout  (pout)
    );

endmodule

// File: rtl/mixram_dp.sv
`timescale 1ns/1ps
module mixram_dp import mixram_pkg::*; #(
    parameter int     A_WIDTH = 36,
    parameter int     B_WIDTH = 9,
    parameter wmode_e A_MODE  = WM_NEW_DATA,
    parameter wmode_e B_MODE  = WM_OLD_DATA
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               a_en,
    input  logic                               a_we,
    input  logic [ADDR_W-1:0]                  a_addr,
    input  logic [data_w(A_WIDTH)-1:0]         a_din,
    input  logic [bus_w(par_w(A_WIDTH))-1:0]   a_pin,
    output logic [data_w(A_WIDTH)-1:0]         a_dout,
    output logic [bus_w(par_w(A_WIDTH))-1:0]   a_pout,
    input  logic                               b_en,
    input  logic                               b_we,
    input  logic [ADDR_W-1:0]                  b_addr,
    input  logic [data_w(B_WIDTH)-1:0]         b_din,
    input  logic [bus_w(par_w(B_WIDTH))-1:0]   b_pin,
    output logic [data_w(B_WIDTH)-1:0]         b_dout,
    output logic [bus_w(par_w(B_WIDTH))-1:0]   b_pout
);
    generate
        if (!width_ok(A_WIDTH)) begin : g_bad_a
            $error("port A width must be 1, 2, 4, 9, 18 or 36");
        end
        if (!width_ok(B_WIDTH)) begin : g_bad_b
            $error("port B width must be 1, 2, 4, 9, 18 or 36");
        end
    endgenerate

    logic [ROW_W-1:0] mem [ROWS];

    row_wr_t          a_wr, b_wr;
    logic             a_go, b_go;
    logic [ROW_W-1:0] a_row_q, b_row_q;
    logic             same_row;

    assign a_row_q  = mem[a_wr.row];
    assign b_row_q  = mem[b_wr.row];
    assign same_row = a_go && (a_wr.row == b_wr.row);

    mixram_port #(.WIDTH(A_WIDTH), .MODE(A_MODE)) port_a_i (
        .clk   (clk),
        .rst   (rst),
        .en    (a_en),
        .we    (a_we),
        .addr  (a_addr),
        .din   (a_din),
        .pin   (a_pin),
        .row_q (a_row_q),
        .wr    (a_wr),
        .wr_go (a_go),
        .dout  (a_dout),
        .pout  (a_pout)
    );

    mixram_port #(.WIDTH(B_WIDTH), .MODE(B_MODE)) port_b_i (
        .clk   (clk),
        .rst   (rst),
        .en    (b_en),
        .we    (b_we),
        .addr  (b_addr),
        .din   (b_din),
        .pin   (b_pin),
        .row_q (b_row_q),
        .wr    (b_wr),
        .wr_go (b_go),
        .dout  (b_dout),
        .pout  (b_pout)
    );

    // Port B is applied after port A; on a shared row both masks are merged.
    always_ff @(posedge clk) begin
        if (a_go) mem[a_wr.row] <= merge_row(a_row_q, a_wr);
        if (b_go) begin
            if (same_row) mem[b_wr.row] <= merge_row(merge_row(b_row_q, a_wr), b_wr);
            else          mem[b_wr.row] <= merge_row(b_row_q, b_wr);
        end
    end

endmodule

// File: rtl/mixram_dp_chk.sv
`timescale 1ns/1ps
module mixram_dp_chk import mixram_pkg::*; #(
    parameter int     A_WIDTH = 36,
    parameter int     B_WIDTH = 9,
    parameter wmode_e A_MODE  = WM_NEW_DATA,
    parameter wmode_e B_MODE  = WM_OLD_DATA
) (
    input logic                               clk,
    input logic                               rst,
    input logic                               a_en,
    input logic                               a_we,
    input logic [data_w(A_WIDTH)-1:0]         a_din,
    input logic [bus_w(par_w(A_WIDTH))-1:0]   a_pin,
    input logic [data_w(A_WIDTH)-1:0]         a_dout,
    input logic [bus_w(par_w(A_WIDTH))-1:0]   a_pout,
    input logic                               b_en,
    input logic                               b_we,
    input logic [data_w(B_WIDTH)-1:0]         b_din,
    input logic [bus_w(par_w(B_WIDTH))-1:0]   b_pin,
    input logic [data_w(B_WIDTH)-1:0]         b_dout,
    input logic [bus_w(par_w(B_WIDTH))-1:0]   b_pout
);
    logic unused_chk;
    assign unused_chk = ^{a_din, a_pin, b_din, b_pin};

    AST_A_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !a_en |=> ($stable(a_dout) && $stable(a_pout))) else $error("A idle change"); // R5
    AST_B_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !b_en |=> ($stable(b_dout) && $stable(b_pout))) else $error("B idle change"); // R5
    AST_A_RST_CLEAR: assert property (@(posedge clk)
        rst |=> (a_dout == '0 && a_pout == '0)) else $error("A not cleared"); // R10
    AST_B_RST_CLEAR: assert property (@(posedge clk)
        rst |=> (b_dout == '0 && b_pout == '0)) else $error("B not cleared"); // R10

    generate
        if (A_MODE == WM_NEW_DATA) begin : g_a_new
            AST_A_WRITE_NEW: assert property (@(posedge clk) disable iff (rst)
                (a_en && a_we) |=> (a_dout == $past(a_din))) else $error("A new data"); // R6
        end
        if (A_MODE == WM_HOLD) begin : g_a_hold
            AST_A_WRITE_HOLD: assert property (@(posedge clk) disable iff (rst)
                (a_en && a_we) |=> ($stable(a_dout) && $stable(a_pout))) else $error("A hold"); // R8
        end
        if (B_MODE == WM_NEW_DATA) begin : g_b_new
            AST_B_WRITE_NEW: assert property (@(posedge clk) disable iff (rst)
                (b_en && b_we) |=> (b_dout == $past(b_din))) else $error("B new data"); // R6
        end
        if (B_MODE == WM_HOLD) begin : g_b_hold
            AST_B_WRITE_HOLD: assert property (@(posedge clk) disable iff (rst)
                (b_en && b_we) |=> ($stable(b_dout) && $stable(b_pout))) else $error("B hold"); // R8
        end
    endgenerate

endmodule

bind mixram_dp mixram_dp_chk #(
    .A_WIDTH (A_WIDTH),
    .B_WIDTH (B_WIDTH),
    .A_MODE  (A_MODE),
    .B_MODE  (B_MODE)
) chk_i (
    .clk    (clk),
    .rst    (rst),
    .a_en   (a_en),
    .a_we   (a_we),
    .a_din  (a_din),
    .a_pin  (a_pin),
    .a_dout (a_dout),
    .a_pout (a_pout),
    .b_en   (b_en),
    .b_we   (b_we),
    .b_din  (b_din),
    .b_pin  (b_pin),
    .b_dout (b_dout),
    .b_pout (b_pout)
);

// File: tb/mixram_dp_tb_top.sv
`timescale 1ns/1ps
module mixram_dp_tb_top;
    import mixram_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    // instance widths and modes: 0 = new data, 1 = old data, 2 = hold
    localparam int W_OF [3][2] = '{'{36, 9}, '{18, 1}, '{2, 4}};
    localparam int M_OF [3][2] = '{'{0, 1}, '{2, 0}, '{1, 2}};

    logic        t_en   [3][2];
    logic        t_we   [3][2];
    logic [13:0] t_addr [3][2];
    logic [35:0] t_wd   [3][2];
    logic [35:0] t_rd   [3][2];
    logic [35:0] exp_q  [3][2];
    logic [35:0] ref_mem [3][512];

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 0;

    logic [31:0] d0a_d; logic [3:0] d0a_p; logic [7:0]  d0b_d; logic d0b_p;
    logic [15:0] d1a_d; logic [1:0] d1a_p; logic        d1b_d; logic d1b_p;
    logic [1:0]  d2a_d; logic       d2a_p; logic [3:0]  d2b_d; logic d2b_p;

    assign t_rd[0][0] = {d0a_p, d0a_d};
    assign t_rd[0][1] = {27'b0, d0b_p, d0b_d};
    assign t_rd[1][0] = {18'b0, d1a_p, d1a_d};
    assign t_rd[1][1] = {34'b0, d1b_p, d1b_d};
    assign t_rd[2][0] = {33'b0, d2a_p, d2a_d};
    assign t_rd[2][1] = {31'b0, d2b_p, d2b_d};

    mixram_dp #(.A_WIDTH(36), .B_WIDTH(9), .A_MODE(WM_NEW_DATA), .B_MODE(WM_OLD_DATA)) dut_i (
        .clk(clk), .rst(rst),
        .a_en(t_en[0][0]), .a_we(t_we[0][0]), .a_addr(t_addr[0][0]),
        .a_din(t_wd[0][0][31:0]), .a_pin(t_wd[0][0][35:32]), .a_dout(d0a_d), .a_pout(d0a_p),
        .b_en(t_en[0][1]), .b_we(t_we[0][1]), .b_addr(t_addr[0][1]),
        .b_din(t_wd[0][1][7:0]), .b_pin(t_wd[0][1][8:8]), .b_dout(d0b_d), .b_pout(d0b_p));

    mixram_dp #(.A_WIDTH(18), .B_WIDTH(1), .A_MODE(WM_HOLD), .B_MODE(WM_NEW_DATA)) dut1_i (
        .clk(clk), .rst(rst),
        .a_en(t_en[1][0]), .a_we(t_we[1][0]), .a_addr(t_addr[1][0]),
        .a_din(t_wd[1][0][15:0]), .a_pin(t_wd[1][0][17:16]), .a_dout(d1a_d), .a_pout(d1a_p),
        .b_en(t_en[1][1]), .b_we(t_we[1][1]), .b_addr(t_addr[1][1]),
        .b_din(t_wd[1][1][0:0]), .b_pin(t_wd[1][1][1:1]), .b_dout(d1b_d), .b_pout(d1b_p));

    mixram_dp #(.A_WIDTH(2), .B_WIDTH(4), .A_MODE(WM_OLD_DATA), .B_MODE(WM_HOLD)) dut2_i (
        .clk(clk), .rst(rst),
        .a_en(t_en[2][0]), .a_we(t_we[2][0]), .a_addr(t_addr[2][0]),
        .a_din(t_wd[2][0][1:0]), .a_pin(t_wd[2][0][2:2]), .a_dout(d2a_d), .a_pout(d2a_p),
        .b_en(t_en[2][1]), .b_we(t_we[2][1]), .b_addr(t_addr[2][1]),
        .b_din(t_wd[2][1][3:0]), .b_pin(t_wd[2][1][4:4]), .b_dout(d2b_d), .b_pout(d2b_p));

    // ---------------- reference model ----------------
    function automatic int bdw(input int w);
        case (w) 1: return 1; 2: return 2; 4: return 4; 9: return 8; 18: return 16; default: return 32; endcase
    endfunction
    function automatic int bpw(input int w);
        case (w) 9: return 1; 18: return 2; 36: return 4; default: return 0; endcase
    endfunction

    function automatic logic [35:0] ref_rd(input int d, input int w, input logic [13:0] a);
        int dw = bdw(w); int pw = bpw(w);
        int row = int'(a[13:5]); int lane = int'(a[4:0]) / dw;
        logic [35:0] r = '0;
        for (int i = 0; i < dw; i++) r[i] = ref_mem[d][row][lane*dw + i];
        for (int i = 0; i < pw; i++) r[dw + i] = ref_mem[d][row][32 + lane*pw + i];
        return r;
    endfunction

    task automatic ref_wr(input int d, input int w, input logic [13:0] a, input logic [35:0] v);
        int dw = bdw(w); int pw = bpw(w);
        int row = int'(a[13:5]); int lane = int'(a[4:0]) / dw;
        for (int i = 0; i < dw; i++) ref_mem[d][row][lane*dw + i] = v[i];
        for (int i = 0; i < pw; i++) ref_mem[d][row][32 + lane*pw + i] = v[dw + i];
    endtask

    function automatic logic [35:0] pword(input int w, input logic [35:0] v);
        logic [35:0] r = '0;
        for (int i = 0; i < bdw(w) + bpw(w); i++) r[i] = v[i];
        return r;
    endfunction

    task automatic idle_all();
        for (int d = 0; d < 3; d++)
            for (int p = 0; p < 2; p++) begin
                t_en[d][p] = 1'b0; t_we[d][p] = 1'b0; t_addr[d][p] = '0; t_wd[d][p] = '0;
            end
    endtask

    task automatic check_all(input int tag);
        for (int d = 0; d < 3; d++)
            for (int p = 0; p < 2; p++) begin
                n_chk++;
                if (t_rd[d][p] !== exp_q[d][p]) begin
                    n_fail++;
                    $display("FAIL R%0d inst %0d port %0d: actual %h expected %h",
                             tag, d, p, t_rd[d][p], exp_q[d][p]);
                end
            end
    endtask

    // one clock: model reads before writes (R9), port A write before port B (R11)
    task automatic step(input int tag);
        for (int d = 0; d < 3; d++)
            for (int p = 0; p < 2; p++)
                if (t_en[d][p]) begin
                    logic [35:0] old = ref_rd(d, W_OF[d][p], t_addr[d][p]);
                    if (!t_we[d][p])        exp_q[d][p] = old;                       // R4
                    else if (M_OF[d][p] == 0) exp_q[d][p] = pword(W_OF[d][p], t_wd[d][p]); // R6
                    else if (M_OF[d][p] == 1) exp_q[d][p] = old;                     // R7
                end                                                                 // R8 keeps
        for (int d = 0; d < 3; d++)
            for (int p = 0; p < 2; p++)
                if (t_en[d][p] && t_we[d][p]) ref_wr(d, W_OF[d][p], t_addr[d][p], t_wd[d][p]);
        @(posedge clk);
        @(negedge clk);
        check_all(tag);
        idle_all();
    endtask

    task automatic do_reset();
        rst = 1'b1;
        idle_all();
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int d = 0; d < 3; d++)
            for (int p = 0; p < 2; p++) exp_q[d][p] = '0;
        check_all(10); // R10 outputs cleared
    endtask

    task automatic drive(input int d, input int p, input bit we, input logic [13:0] a, input logic [35:0] v);
        t_en[d][p] = 1'b1; t_we[d][p] = we; t_addr[d][p] = a; t_wd[d][p] = v;
    endtask

    typedef struct packed {
        int          d;
        int          p;
        bit          we;
        logic [13:0] addr;
        logic [35:0] wd;
        int          tag;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VEC [NV] = '{
        '{0, 0, 1'b1, 14'h0020, 36'hA12345678, 6},  // R6 wide write, new data out
        '{0, 1, 1'b0, 14'h0020, 36'h0,         2},  // R2 byte lane 0 of the wide word
        '{0, 1, 1'b0, 14'h003F, 36'h0,         1},  // R1 low bits ignored, R3 parity bit 3
        '{0, 1, 1'b1, 14'h0028, 36'h1FF,       7},  // R7 narrow write shows old byte
        '{0, 0, 1'b0, 14'h003F, 36'h0,         2},  // R2 byte merged into wide word
        '{1, 0, 1'b1, 14'h0010, 36'h2BEEF,     8},  // R8 hold on write
        '{1, 0, 1'b0, 14'h0010, 36'h0,         4},  // R4 registered read
        '{1, 0, 1'b1, 14'h0000, 36'h1CAFE,     8},  // R8 hold keeps last read
        '{1, 1, 1'b1, 14'h0011, 36'h2,         3},  // R3 parity input ignored at width 1
        '{1, 0, 1'b0, 14'h001F, 36'h0,         1},  // R1 bit 17 cleared, low bits ignored
        '{1, 1, 1'b0, 14'h0001, 36'h0,         2},  // R2 single bit lane
        '{2, 1, 1'b1, 14'h0104, 36'h19,        8},  // R8 hold, parity dropped
        '{2, 1, 1'b0, 14'h0107, 36'h0,         1},  // R1 nibble read, low bits ignored
        '{2, 0, 1'b1, 14'h0104, 36'h2,         7},  // R7 old two-bit value
        '{2, 0, 1'b0, 14'h0107, 36'h0,         1},  // R1 upper pair of the nibble
        '{2, 1, 1'b0, 14'h0104, 36'h0,         3}   // R3 narrow parity output zero
    };

    initial begin
        idle_all();
        for (int d = 0; d < 3; d++)
            for (int p = 0; p < 2; p++) exp_q[d][p] = '0;
        do_reset();

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].d, VEC[i].p, VEC[i].we, VEC[i].addr, VEC[i].wd);
            step(VEC[i].tag);
        end

        // R5: disabled port with write enable high writes nothing
        t_we[0][0] = 1'b1; t_addr[0][0] = 14'h0020; t_wd[0][0] = 36'h0;
        step(5);
        drive(0, 0, 1'b0, 14'h0020, 36'h0);
        step(5);

        // R9: read on B while A rewrites the same row
        drive(0, 0, 1'b1, 14'h0020, 36'h50F0F0F0F);
        drive(0, 1, 1'b0, 14'h0030, 36'h0);
        step(9);
        drive(0, 1, 1'b0, 14'h0030, 36'h0);
        step(9);

        // R11: both ports write disjoint bits of row 5 together
        drive(1, 0, 1'b1, 14'h00A0, 36'h31234);
        drive(1, 1, 1'b1, 14'h00B4, 36'h1);
        step(11);
        drive(1, 0, 1'b0, 14'h00A0, 36'h0);
        drive(1, 1, 1'b0, 14'h00B4, 36'h0);
        step(11);

        // R10: reset mid-run clears outputs, contents survive
        do_reset();
        drive(1, 0, 1'b0, 14'h0010, 36'h0);
        drive(0, 1, 1'b0, 14'h0038, 36'h0);
        step(10);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule